// File: doc/BRIEF.md
# Same-Sign Binary32 Floating-Point Adder

This block adds two 32-bit binary floating-point operands (1 sign bit, 8 exponent bits, 23 stored fraction bits, exponent bias 127) that carry the same sign. The sum is a 32-bit word in the same format. The block is purely combinational, so the result follows the inputs within the same cycle. A surrounding datapath that has already routed opposite-sign pairs elsewhere can use it as a magnitude-adding unit.

Each operand is split into its fields, and the implicit leading 1 is put back in front of the fraction. The operand with the smaller exponent is shifted right by the exponent difference. The shift keeps a guard bit, a round bit and a sticky bit. The two mantissas are then added. A carry out of the add moves the sum right one place and raises the exponent by one. The result is then rounded to nearest with ties to even. A carry out of that rounding raises the exponent again. An exponent that reaches 255 turns the result into infinity. NaN, infinity and zero operands bypass this path through a fixed priority. Operands with an exponent field of 0 count as zero, so denormal inputs are flushed.

Top module: `fp32_same_sign_adder`

## Requirements
- R1: For every input pair with no NaN operand, bit 31 of the result equals the sign bit of the first operand `a_i`. The one exception is when both operands are zero class: the result is then negative only if both signs are 1.
- R2: Two normal operands (exponent field 1 to 254) whose exact sum fits in 24 significant bits give that exact sum. Examples: 0x3F800000+0x3F800000=0x40000000, and 0x43640000+0x42690000=0x438F2000.
- R3: The operand with the smaller exponent is aligned to the larger one. Swapping `a_i` and `b_i` leaves the result unchanged.
- R4: If the bits dropped below the kept 24-bit mantissa are worth more than half a unit in the last place, the result rounds up. If they are worth less, it rounds down. Example: 0x3F800000+0x33C00000=0x3F800001.
- R5: An exact half-unit remainder rounds to the neighbour with an even last fraction bit. Examples: 0x3F800000+0x33800000=0x3F800000, and 0x3F800001+0x33800000=0x3F800002.
- R6: A set bit anywhere below the round position counts toward rounding. Example: 0x3F800000+0x33800001=0x3F800001.
- R7: For two normal operands with a finite result, the result exponent field equals the larger input exponent, or that exponent plus 1. The plus 1 comes from a carry of the mantissa add or of the rounding. Examples: 0x3FFFFFFF+0x3FFFFFFF=0x407FFFFF, and 0x3FFFFFFF+0x33800000=0x40000000.
- R8: If the final exponent reaches 255, the result is infinity (exponent 0xFF, fraction 0) with the operands' sign. This holds when the exponent gets there through the add carry or through the rounding carry.
- R9: If either operand is a NaN (exponent 0xFF, fraction not 0), the result is 0x7FC00000.
- R10: If neither operand is a NaN and one is infinity (exponent 0xFF, fraction 0), the result is that infinity word. `a_i` is checked first.
- R11: A zero-class operand (exponent field 0, any fraction) gives the other operand unchanged, provided that operand is finite and not zero class. If both operands are zero class, the result is a signed zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand, binary32 encoding |
| b_i | input | 32 | Second operand, binary32 encoding, same sign as a_i |
| sum_o | output | 32 | Rounded sum, binary32 encoding |

## Verification
The mantissa-add carry and the rounding carry can both move the exponent, and both can happen for the same operand pair. In that case the exponent may go past 254 and into infinity. The tests provoke the rounding carry alone by adding a half-unit tie to an all-ones mantissa. They provoke it together with overflow by adding a tie to the largest finite value, and they provoke add-carry overflow by adding the largest finite value to itself. In each case the expected word is worked out from the exact real sum. Each case also runs with the operands swapped.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    localparam int FP_EXP_W  = 8;
    localparam int FP_FRAC_W = 23;

    // operand category after field decode
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fp_class_t;

endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack
    import fpa_pkg::*;
#(
    parameter int EXP_W  = FP_EXP_W,
    parameter int FRAC_W = FP_FRAC_W
) (
    input  logic [EXP_W+FRAC_W-1:0] field_i,
    output fp_class_t               cls_o,
    output logic [EXP_W-1:0]        exp_o,
    output logic [FRAC_W:0]         mant_o
);
    localparam logic [EXP_W-1:0] EXP_MAX = '1;

    logic [FRAC_W-1:0] frac;

    assign exp_o = field_i[EXP_W+FRAC_W-1:FRAC_W];
    assign frac  = field_i[FRAC_W-1:0];

    always_comb begin
        if (exp_o == '0) begin
            cls_o = CLS_ZERO;
        end else if (exp_o == EXP_MAX) begin
            cls_o = (frac == '0) ? CLS_INF : CLS_NAN;
        end else begin
            cls_o = CLS_NORM;
        end
        // hidden bit restored for normal values only
        mant_o = {(cls_o == CLS_NORM), frac};
    end

endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
    parameter int EXP_W  = 8,
    parameter int MANT_W = 24
) (
    input  logic [EXP_W-1:0]  exp_a_i,
    input  logic [MANT_W-1:0] mant_a_i,
    input  logic [EXP_W-1:0]  exp_b_i,
    input  logic [MANT_W-1:0] mant_b_i,
    output logic [EXP_W-1:0]  exp_big_o,
    output logic [MANT_W+2:0] big_ext_o,
    output logic [MANT_W+2:0] small_ext_o
);
    localparam int EXT_W = MANT_W + 3;
    localparam int SH_W  = $clog2(EXT_W + 1);

    logic              swap;
    logic [EXP_W-1:0]  exp_small;
    logic [EXP_W-1:0]  diff;
    logic [SH_W-1:0]   amt;
    logic [EXT_W-1:0]  small_raw;
    logic [EXT_W-1:0]  shifted;
    logic [EXT_W-1:0]  lost_mask;
    logic              sticky;

    always_comb begin
        swap      = (exp_b_i > exp_a_i);
        exp_big_o = swap ? exp_b_i : exp_a_i;
        exp_small = swap ? exp_a_i : exp_b_i;
        big_ext_o = {(swap ? mant_b_i : mant_a_i), 3'b000};
        small_raw = {(swap ? mant_a_i : mant_b_i), 3'b000};
        diff      = exp_big_o - exp_small;

        // saturate: beyond EXT_W everything lands in sticky
        if (diff > EXP_W'(EXT_W)) begin
            amt = SH_W'(EXT_W);
        end else begin
            amt = SH_W'(diff);
        end

        shifted   = small_raw >> amt;
        lost_mask = ~({EXT_W{1'b1}} << amt);
        sticky    = |(small_raw & lost_mask);

        small_ext_o = {shifted[EXT_W-1:1], shifted[0] | sticky};
    end

endmodule

// File: rtl/fpa_round.sv
module fpa_round #(
    parameter int EXP_W  = 8,
    parameter int MANT_W = 24
) (
    input  logic [EXP_W-1:0]  exp_big_i,
    input  logic [MANT_W+2:0] big_ext_i,
    input  logic [MANT_W+2:0] small_ext_i,
    output logic              ovf_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic [MANT_W-2:0] frac_o
);
    localparam int EXT_W = MANT_W + 3;
    localparam logic [EXP_W:0] EXP_LIMIT = {1'b0, {EXP_W{1'b1}}};

    logic [EXT_W:0]    sum;
    logic [EXT_W-1:0]  norm;
    logic [EXP_W:0]    exp_n;
    logic [EXP_W:0]    exp_r;
    logic [MANT_W-1:0] keep;
    logic              guard_b, round_b, sticky_b, up;
    logic [MANT_W:0]   rnd;

    always_comb begin
        sum = {1'b0, big_ext_i} + {1'b0, small_ext_i};

        // add carry: one place right, dropped bit folds into sticky
        if (sum[EXT_W]) begin
            norm  = {sum[EXT_W:2], sum[1] | sum[0]};
            exp_n = {1'b0, exp_big_i} + 1'b1;
        end else begin
            norm  = sum[EXT_W-1:0];
            exp_n = {1'b0, exp_big_i};
        end

        keep     = norm[EXT_W-1:3];
        guard_b  = norm[2];
        round_b  = norm[1];
        sticky_b = norm[0];
        up       = guard_b & (round_b | sticky_b | keep[0]);
        rnd      = {1'b0, keep} + {{MANT_W{1'b0}}, up};

        // rounding carry: mantissa became 10.00..0
        exp_r  = rnd[MANT_W] ? exp_n + 1'b1 : exp_n;
        frac_o = rnd[MANT_W] ? rnd[MANT_W-1:1] : rnd[MANT_W-2:0];
        ovf_o  = (exp_r >= EXP_LIMIT);
        exp_o  = exp_r[EXP_W-1:0];
    end

endmodule

// File: rtl/fp32_same_sign_adder.sv
module fp32_same_sign_adder
    import fpa_pkg::*;
#(
    parameter int EXP_W  = FP_EXP_W,
    parameter int FRAC_W = FP_FRAC_W
) (
    input  logic [EXP_W+FRAC_W:0] a_i,
    input  logic [EXP_W+FRAC_W:0] b_i,
    output logic [EXP_W+FRAC_W:0] sum_o
);
    localparam int MANT_W = FRAC_W + 1;
    localparam int MSB    = EXP_W + FRAC_W;
    localparam logic [MSB:0] QUIET_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    fp_class_t          cls_a, cls_b;
    logic [EXP_W-1:0]   exp_a, exp_b, exp_big, exp_res;
    logic [MANT_W-1:0]  mant_a, mant_b;
    logic [MANT_W+2:0]  big_ext, small_ext;
    logic [FRAC_W-1:0]  frac_res;
    logic               ovf;
    logic               sign_res;

    fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_a (
        .field_i (a_i[MSB-1:0]),
        .cls_o   (cls_a),
        .exp_o   (exp_a),
        .mant_o  (mant_a)
    );

    fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack_b (
        .field_i (b_i[MSB-1:0]),
        .cls_o   (cls_b),
        .exp_o   (exp_b),
        .mant_o  (mant_b)
    );

    fpa_align #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_align (
        .exp_a_i     (exp_a),
        .mant_a_i    (mant_a),
        .exp_b_i     (exp_b),
        .mant_b_i    (mant_b),
        .exp_big_o   (exp_big),
        .big_ext_o   (big_ext),
        .small_ext_o (small_ext)
    );

    fpa_round #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_round (
        .exp_big_i   (exp_big),
        .big_ext_i   (big_ext),
        .small_ext_i (small_ext),
        .ovf_o       (ovf),
        .exp_o       (exp_res),
        .frac_o      (frac_res)
    );

    assign sign_res = a_i[MSB];

    // special operands take priority over the arithmetic path
    always_comb begin
        if (cls_a == CLS_NAN || cls_b == CLS_NAN) begin
            sum_o = QUIET_NAN;
        end else if (cls_a == CLS_INF) begin
            sum_o = a_i;
        end else if (cls_b == CLS_INF) begin
            sum_o = b_i;
        end else if (cls_a == CLS_ZERO && cls_b == CLS_ZERO) begin
            sum_o = {a_i[MSB] & b_i[MSB], {MSB{1'b0}}};
        end else if (cls_a == CLS_ZERO) begin
            sum_o = b_i;
        end else if (cls_b == CLS_ZERO) begin
            sum_o = a_i;
        end else if (ovf) begin
            sum_o = {sign_res, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            sum_o = {sign_res, exp_res, frac_res};
        end
    end

endmodule

// File: rtl/fpa_checker.sv
module fpa_checker #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic [EXP_W+FRAC_W:0] a_i,
    input logic [EXP_W+FRAC_W:0] b_i,
    input logic [EXP_W+FRAC_W:0] sum_o
);
    localparam int MSB = EXP_W + FRAC_W;
    localparam logic [EXP_W-1:0] EMAX = '1;

    logic [EXP_W-1:0] ea, eb, es, emx;
    logic nan_a, nan_b, inf_a, inf_b, zer_a, zer_b, nrm_a, nrm_b;

    always_comb begin
        ea    = a_i[MSB-1:FRAC_W];
        eb    = b_i[MSB-1:FRAC_W];
        es    = sum_o[MSB-1:FRAC_W];
        emx   = (ea > eb) ? ea : eb;
        nan_a = (ea == EMAX) && (a_i[FRAC_W-1:0] != '0);
        nan_b = (eb == EMAX) && (b_i[FRAC_W-1:0] != '0);
        inf_a = (ea == EMAX) && (a_i[FRAC_W-1:0] == '0);
        inf_b = (eb == EMAX) && (b_i[FRAC_W-1:0] == '0);
        zer_a = (ea == '0);
        zer_b = (eb == '0);
        nrm_a = !zer_a && (ea != EMAX);
        nrm_b = !zer_b && (eb != EMAX);

        // R9
        a_r9_nan_quiet: assert (!(nan_a || nan_b) || sum_o == {1'b0, EMAX, 1'b1, {(FRAC_W-1){1'b0}}})
            else $error("R9 NaN operand not mapped to quiet NaN");
        // R10
        a_r10_inf_pass: assert (!(!nan_a && !nan_b && inf_a) || sum_o == a_i)
            else $error("R10 infinity operand not returned");
        // R11
        a_r11_zero_pass: assert (!(zer_a && nrm_b) || sum_o == b_i)
            else $error("R11 zero-class operand altered result");
        // R1
        a_r1_sign_follow: assert (!(nrm_a && nrm_b) || sum_o[MSB] == a_i[MSB])
            else $error("R1 result sign differs from operand sign");
        // R7
        a_r7_exp_window: assert (!(nrm_a && nrm_b) || es == emx || es == emx + 1'b1)
            else $error("R7 result exponent outside window");
    end

endmodule

bind fp32_same_sign_adder fpa_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_fpa_checker (
    .a_i   (a_i),
    .b_i   (b_i),
    .sum_o (sum_o)
);

// File: tb/test_fp32_same_sign_adder.sv
module test_fp32_same_sign_adder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a, b, y;
    int          n_total = 0;
    int          n_fail  = 0;
    logic        done    = 1'b0;

    always #2 clk = ~clk;

    fp32_same_sign_adder i_fp32_same_sign_adder (
        .a_i   (a),
        .b_i   (b),
        .sum_o (y)
    );

    task automatic check(input string req, input logic [31:0] av, input logic [31:0] bv,
                         input logic [31:0] expv);
        @(negedge clk);
        a = av;
        b = bv;
        #1;
        n_total++;
        if (y !== expv) begin
            n_fail++;
            $display("FAIL %s: %h + %h actual %h expected %h", req, av, bv, y, expv);
        end
    endtask

    // both orders must agree (R3)
    task automatic check_both(input string req, input logic [31:0] av, input logic [31:0] bv,
                              input logic [31:0] expv);
        check(req, av, bv, expv);
        check({req, " R3 swapped"}, bv, av, expv);
    endtask

    task automatic t_reset_state;
        check("R11 idle zero inputs", 32'h0000_0000, 32'h0000_0000, 32'h0000_0000);
    endtask

    task automatic t_exact;
        check_both("R2 1+1", 32'h3F80_0000, 32'h3F80_0000, 32'h4000_0000);
        check_both("R2 1.5+2.25", 32'h3FC0_0000, 32'h4010_0000, 32'h4070_0000);
        check_both("R2 228+58.25", 32'h4364_0000, 32'h4269_0000, 32'h438F_2000);
        check_both("R1 negative 228+58.25", 32'hC364_0000, 32'hC269_0000, 32'hC38F_2000);
    endtask

    task automatic t_round;
        check_both("R4 above half", 32'h3F80_0000, 32'h33C0_0000, 32'h3F80_0001);
        check_both("R4 far below half", 32'h3F80_0000, 32'h2180_0000, 32'h3F80_0000);
        check_both("R5 tie even stays", 32'h3F80_0000, 32'h3380_0000, 32'h3F80_0000);
        check_both("R5 tie odd up", 32'h3F80_0001, 32'h3380_0000, 32'h3F80_0002);
        check_both("R6 sticky breaks tie", 32'h3F80_0000, 32'h3380_0001, 32'h3F80_0001);
    endtask

    task automatic t_carry;
        check_both("R7 add carry", 32'h3FFF_FFFF, 32'h3FFF_FFFF, 32'h407F_FFFF);
        check_both("R7 round carry", 32'h3FFF_FFFF, 32'h3380_0000, 32'h4000_0000);
    endtask

    task automatic t_overflow;
        check_both("R8 add carry to inf", 32'h7F7F_FFFF, 32'h7F7F_FFFF, 32'h7F80_0000);
        check_both("R8 negative to inf", 32'hFF7F_FFFF, 32'hFF7F_FFFF, 32'hFF80_0000);
        check_both("R8 round carry to inf", 32'h7F7F_FFFF, 32'h7300_0000, 32'h7F80_0000);
        check_both("R8 2^127 doubled", 32'h7F00_0000, 32'h7F00_0000, 32'h7F80_0000);
    endtask

    task automatic t_specials;
        check_both("R9 nan with one", 32'h7FC0_0001, 32'h3F80_0000, 32'h7FC0_0000);
        check_both("R9 nan with inf", 32'hFF80_0001, 32'hFF80_0000, 32'h7FC0_0000);
        check_both("R10 inf with one", 32'h7F80_0000, 32'h3F80_0000, 32'h7F80_0000);
        check_both("R10 neg inf", 32'hFF80_0000, 32'hBF80_0000, 32'hFF80_0000);
    endtask

    task automatic t_zero;
        check_both("R11 zero plus 228", 32'h0000_0000, 32'h4364_0000, 32'h4364_0000);
        check_both("R11 denormal flushed", 32'h0000_0001, 32'h3F80_0000, 32'h3F80_0000);
        check("R11 neg zeros", 32'h8000_0000, 32'h8000_0000, 32'h8000_0000);
        check("R11 mixed zeros", 32'h0000_0000, 32'h8000_0000, 32'h0000_0000);
    endtask

    initial begin
        a = '0;
        b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_exact();
        t_round();
        t_carry();
        t_overflow();
        t_specials();
        t_zero();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule